// File: doc/BRIEF.md
# Selectable Baud Clock Generator

This block turns a 1.8432 MHz reference clock into a family of serial bit-rate strobes. It then passes one of them to its output, chosen by a 3-bit rate code. Every output is a clock enable that is high for exactly one reference cycle. Downstream logic, such as a loopback router or a test-pattern shifter, advances one bit each time the enable is high. Nothing in the block uses a derived clock.

The six standard rates are 9600, 4800, 2400, 1200, 600 and 300 baud. An active-low high-rate request adds two things: a 19200 baud choice, and a 76.8 kHz strobe for an attached converter. All strobes come from one free-running divider chain. A slow strobe therefore always lands on a cycle where every faster strobe is also high. Changing the rate code never produces a shortened bit period: the new rate first fires on its own next natural edge.

Top module: `baud_rate_select`

## Requirements
- R1: While `rst_n` is low, `baud_en` and `aux_en` are low. After `rst_n` goes high, the divider chain counts reference cycles from zero.
- R2: Rate codes 0 to 5 select 9600, 4800, 2400, 1200, 600 and 300 baud. These are reference divisors of 192, 384, 768, 1536, 3072 and 6144.
- R3: Rate code 6 with `hi_rate_n` low selects 19200 baud, a reference divisor of 96.
- R4: Rate code 6 with `hi_rate_n` high falls back to 9600 baud, a divisor of 192.
- R5: Rate code 7 holds `baud_en` low.
- R6: While `hi_rate_n` is low, `aux_en` pulses once every 24 reference cycles (76.8 kHz). While `hi_rate_n` is high, `aux_en` stays low.
- R7: Let n be the number of rising reference edges since reset release, counting from 1. A strobe of divisor D is high in the cycle after edge n exactly when n is a multiple of D. It depends only on the code and mode sampled at that edge, so the strobe phase is independent of any earlier rate selection. While `hi_rate_n` is low, every `baud_en` pulse coincides with an `aux_en` pulse.
- R8: Neither `baud_en` nor `aux_en` is ever high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 1.8432 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Rate code: 0..5 base rates, 6 high rate, 7 idle |
| hi_rate_n | input | 1 | Active-low high-rate request |
| baud_en | output | 1 | Selected bit-rate strobe, one cycle wide |
| aux_en | output | 1 | 76.8 kHz converter strobe, one cycle wide |

## Verification
The bench changes the rate code and the mode in the middle of a period. A design that restarts its divider on a change would emit a runt pulse at the wrong time, and the per-cycle comparison against an absolute-count model would catch it. Code 6 is driven in both modes, because a wrong fallback would double or drop pulses. Code 7 is checked for total silence. The bench applies a reset in the middle of the run, which exposes a chain that does not restart its phase. It also counts pulses over whole multiples of each divisor, which catches a divisor that is off by one.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef logic [2:0] rate_code_t;
  localparam rate_code_t CODE_HIGH = 3'd6;
  localparam rate_code_t CODE_IDLE = 3'd7;
endpackage

// File: rtl/baud_prescale.sv
module baud_prescale #(
  parameter int PRE_DIV = 24
) (
  input  logic clk,
  input  logic rst_n,
  output logic wrap
);
  localparam int PRE_W = $clog2(PRE_DIV);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0] cnt_q;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (wrap) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/baud_chain.sv
module baud_chain #(
  parameter int CHAIN_BITS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  step,
  output logic [CHAIN_BITS-1:0] ticks
);
  logic [CHAIN_BITS-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  // tick j fires once every 2^(j+1) prescaler wraps
  for (genvar j = 0; j < CHAIN_BITS; j++) begin : g_tick
    assign ticks[j] = step & (&cnt_q[j:0]);
  end
endmodule

// File: rtl/baud_mux.sv
module baud_mux
  import baud_pkg::*;
#(
  parameter int CHAIN_BITS = 8,
  parameter int HI_IDX     = 1,
  parameter int NUM_BASE   = 6
) (
  input  logic [CHAIN_BITS-1:0] ticks,
  input  rate_code_t            rate_sel,
  input  logic                  hi_mode,
  output logic                  sel_tick
);
  localparam int BASE_IDX = HI_IDX + 1;

  always_comb begin
    sel_tick = 1'b0;
    if (rate_sel == CODE_IDLE) begin
      sel_tick = 1'b0;
    end else if (rate_sel == CODE_HIGH) begin
      sel_tick = hi_mode ? ticks[HI_IDX] : ticks[BASE_IDX];
    end else begin
      for (int k = 0; k < NUM_BASE; k++) begin
        if (rate_sel == 3'(k)) sel_tick = ticks[BASE_IDX + k];
      end
    end
  end
endmodule

// File: rtl/baud_rate_select.sv
module baud_rate_select
  import baud_pkg::*;
#(
  parameter int PRE_DIV    = 24,
  parameter int CHAIN_BITS = 8,
  parameter int HI_IDX     = 1,
  parameter int NUM_BASE   = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] rate_sel,
  input  logic       hi_rate_n,
  output logic       baud_en,
  output logic       aux_en
);
  logic                  pre_wrap;
  logic [CHAIN_BITS-1:0] ticks;
  logic                  sel_tick;
  logic                  hi_mode;

  assign hi_mode = ~hi_rate_n;

  baud_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .wrap  (pre_wrap)
  );

  baud_chain #(.CHAIN_BITS(CHAIN_BITS)) u_chain (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (pre_wrap),
    .ticks (ticks)
  );

  baud_mux #(
    .CHAIN_BITS(CHAIN_BITS),
    .HI_IDX    (HI_IDX),
    .NUM_BASE  (NUM_BASE)
  ) u_mux (
    .ticks    (ticks),
    .rate_sel (rate_sel),
    .hi_mode  (hi_mode),
    .sel_tick (sel_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      baud_en <= 1'b0;
      aux_en  <= 1'b0;
    end else begin
      baud_en <= sel_tick;
      aux_en  <= pre_wrap & hi_mode;
    end
  end
endmodule

// File: rtl/baud_rate_select_chk.sv
module baud_rate_select_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] rate_sel,
  input logic       hi_rate_n,
  input logic       baud_en,
  input logic       aux_en
);
  AST_BAUD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    baud_en |=> !baud_en); // R8
  AST_AUX_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    aux_en |=> !aux_en); // R8
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == 3'd7) |=> !baud_en); // R5
  AST_AUX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    hi_rate_n |=> !aux_en); // R6
  AST_BAUD_ON_AUX: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_rate_n |=> (!baud_en || aux_en)); // R7
endmodule

bind baud_rate_select baud_rate_select_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rate_sel  (rate_sel),
  .hi_rate_n (hi_rate_n),
  .baud_en   (baud_en),
  .aux_en    (aux_en)
);

// File: tb/tb_baud_rate_select.sv
module tb_baud_rate_select;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate_sel = 3'd0;
  logic       hi_rate_n = 1'b1;
  logic       baud_en;
  logic       aux_en;

  int total = 0;
  int bad = 0;
  int edges = 0;
  logic exp_baud = 1'b0;
  logic exp_aux = 1'b0;
  string tag = "R1";
  int pulses = 0;

  always #5 clk = ~clk;

  baud_rate_select dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .hi_rate_n(hi_rate_n), .baud_en(baud_en), .aux_en(aux_en)
  );

  function automatic int divisor(input logic [2:0] code, input logic hi_n);
    if (code == 3'd7) return 0;
    if (code == 3'd6) return hi_n ? 192 : 96;
    return 192 << code;
  endfunction

  function automatic string req_of(input logic [2:0] code, input logic hi_n);
    if (code == 3'd7) return "R5";
    if (code == 3'd6) return hi_n ? "R4" : "R3";
    return "R2/R7";
  endfunction

  // behavioural reference: absolute edge count since reset release
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0; exp_baud = 1'b0; exp_aux = 1'b0; tag = "R1";
    end else begin
      int d;
      edges = edges + 1;
      d = divisor(rate_sel, hi_rate_n);
      exp_baud = (d != 0) && (edges % d == 0);
      exp_aux  = !hi_rate_n && (edges % 24 == 0);
      tag = req_of(rate_sel, hi_rate_n);
    end
  end

  always @(negedge clk) begin
    total++;
    if (baud_en !== exp_baud) begin
      bad++;
      $display("FAIL %s baud_en act=%0b exp=%0b edge=%0d", tag, baud_en, exp_baud, edges);
    end
    total++;
    if (aux_en !== exp_aux) begin
      bad++;
      $display("FAIL R6 aux_en act=%0b exp=%0b edge=%0d", aux_en, exp_aux, edges);
    end
    if (baud_en) pulses++;
  end

  task automatic window(input logic [2:0] code, input logic hi_n, input int n_per,
                        input string req);
    int d;
    @(negedge clk);
    rate_sel = code; hi_rate_n = hi_n;
    d = divisor(code, hi_n);
    repeat (d == 0 ? 5000 : d) @(negedge clk);
    pulses = 0;
    repeat (d == 0 ? 5000 : d * n_per) @(negedge clk);
    total++;
    if (pulses != (d == 0 ? 0 : n_per)) begin
      bad++;
      $display("FAIL %s pulse count act=%0d exp=%0d code=%0d", req, pulses,
               d == 0 ? 0 : n_per, code);
    end
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    total++;
    if (baud_en !== 1'b0 || aux_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset outputs act=%0b%0b exp=00", baud_en, aux_en);
    end
    rst_n = 1'b1;
    window(3'd0, 1'b1, 4, "R2");
    window(3'd1, 1'b1, 3, "R2");
    window(3'd2, 1'b0, 3, "R2");
    window(3'd3, 1'b1, 2, "R2");
    window(3'd4, 1'b0, 2, "R2");
    window(3'd5, 1'b1, 2, "R2");
    window(3'd6, 1'b0, 6, "R3");
    window(3'd6, 1'b1, 6, "R4");
    window(3'd7, 1'b0, 1, "R5");
    // mid-period switching: R7 phase is held by the shared chain
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      rate_sel = 3'((i * 5) % 8);
      hi_rate_n = i[0];
      repeat (137 + i * 11) @(negedge clk);
    end
    // mid-run reset restarts phase (R1)
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    total++;
    if (baud_en !== 1'b0 || aux_en !== 1'b0) begin
      bad++;
      $display("FAIL R1 mid reset outputs act=%0b%0b exp=00", baud_en, aux_en);
    end
    rate_sel = 3'd6; hi_rate_n = 1'b0;
    rst_n = 1'b1;
    repeat (400) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule